// File: doc/BRIEF.md
# Reduced MIPS Integer Execute Unit (ALU with Instruction Decoder)

This block executes the integer arithmetic, logic, shift, compare and address-generation work of a reduced MIPS instruction set. It has no multiply, divide, floating point or coprocessor operations. A 32-bit instruction word arrives with the two source register values already read out. The decoder looks at the opcode, and at the funct field when the opcode is zero. From these it chooses an ALU operation, how the 16-bit immediate is widened, and which values feed the two ALU operands. The combinational ALU result is captured in one output register.

Loads and stores use the same path to form their effective address, base plus sign-extended offset. Branch comparison, the register file, forwarding and the pipeline around the unit belong to neighbouring blocks. Encodings outside the supported set still produce a defined value, the sum of the two register operands, but are marked as not valid.

Field positions in the instruction word: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0].

Top module: `mips_exec_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid is 0 and out_result is 0.
- R2: A supported instruction presented with in_valid high in one cycle gives out_valid high and its result on out_result after the next rising clock edge.
- R3: ADDIU (opcode 0x09) and every load and store address computation (opcodes 0x20, 0x21, 0x23, 0x24, 0x25, 0x28, 0x29, 0x2B) return rs plus the sign-extended immediate, modulo 2^32.
- R4: ANDI, ORI and XORI (opcodes 0x0C, 0x0D, 0x0E) combine rs with the zero-extended immediate.
- R5: SLTI (0x0A) compares rs with the sign-extended immediate as signed numbers. SLTIU (0x0B) sign-extends the immediate and then compares as unsigned numbers.
- R6: LUI (0x0F) returns the immediate in bits [31:16] and zeros in bits [15:0], whatever the rs value.
- R7: With opcode 0, SLL, SRL and SRA (funct 0x00, 0x02, 0x03) shift rt by the shamt field.
- R8: SLLV, SRLV and SRAV (funct 0x04, 0x06, 0x07) shift rt by rs[4:0] only, ignoring rs[31:5].
- R9: SRA and SRAV fill vacated bits with rt[31]. SRL and SRLV fill them with zeros.
- R10: NOR (funct 0x27) returns the bitwise AND of the inverted operands. AND, OR and XOR (funct 0x24, 0x25, 0x26) return the bitwise functions of rs and rt.
- R11: SLT (funct 0x2A) compares signed and SLTU (funct 0x2B) compares unsigned. Each returns 1 when rs is less than rt and 0 otherwise.
- R12: ADDU (funct 0x21) and SUBU (funct 0x23) wrap modulo 2^32, with no overflow indication.
- R13: An unsupported opcode, or an unsupported funct under opcode 0, gives out_valid 0 after the next edge, with out_result equal to rs plus rt.
- R14: In a cycle with in_valid low, out_result keeps its value and out_valid goes to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr_word | input | 32 | Encoded instruction |
| rs_val | input | 32 | Value of the rs source register |
| rt_val | input | 32 | Value of the rt source register |
| out_valid | output | 1 | out_result holds the result of a supported instruction |
| out_result | output | 32 | Registered ALU result |

## Verification
Some properties are checked by assertions on every cycle: the ALU invariants hold for whatever operands arrive. These cover sign fill on arithmetic right shifts, the 0-or-1 result of compares, the no-overlap property of NOR with its operands, and the modular inverse relation of add. At the top level, assertions also check that out_valid follows in_valid and that the result holds during idle cycles. Other behaviours only show up in the bench's directed instruction scenarios. These include the per-opcode choice of immediate extension, the signed-versus-unsigned split between SLTI and SLTIU, LUI ignoring rs, variable shifts masking rs to five bits, and unsupported encodings being marked not valid.

// File: rtl/mips_exec_pkg.sv
package mips_exec_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned FIELD_W = 6;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN, EXT_ZERO, EXT_UPPER
    } imm_ext_e;

    typedef enum logic {
        ASRC_RS, ASRC_RT
    } a_src_e;

    typedef enum logic [1:0] {
        BSRC_RT, BSRC_IMM, BSRC_SHAMT, BSRC_RS
    } b_src_e;

    typedef struct packed {
        alu_op_e  op;
        imm_ext_e ext;
        a_src_e   asrc;
        b_src_e   bsrc;
        logic     known;
    } dec_ctl_t;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_ADDIU   = 6'h09;
    localparam logic [5:0] OPC_SLTI    = 6'h0A;
    localparam logic [5:0] OPC_SLTIU   = 6'h0B;
    localparam logic [5:0] OPC_ANDI    = 6'h0C;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] OPC_XORI    = 6'h0E;
    localparam logic [5:0] OPC_LUI     = 6'h0F;
    localparam logic [5:0] OPC_LDB     = 6'h20;
    localparam logic [5:0] OPC_LDH     = 6'h21;
    localparam logic [5:0] OPC_LDW     = 6'h23;
    localparam logic [5:0] OPC_LDBU    = 6'h24;
    localparam logic [5:0] OPC_LDHU    = 6'h25;
    localparam logic [5:0] OPC_STB     = 6'h28;
    localparam logic [5:0] OPC_STH     = 6'h29;
    localparam logic [5:0] OPC_STW     = 6'h2B;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/mips_op_decoder.sv
module mips_op_decoder
    import mips_exec_pkg::*;
(
    input  logic [FIELD_W-1:0] opcode,
    input  logic [FIELD_W-1:0] funct,
    output dec_ctl_t           ctl
);

    dec_ctl_t rtype_ctl;

    // Register-register group selected by funct
    always_comb begin
        rtype_ctl = '{op: ALU_ADD, ext: EXT_SIGN, asrc: ASRC_RS, bsrc: BSRC_RT, known: 1'b1};
        unique case (funct)
            FN_SLL:  begin rtype_ctl.op = ALU_SLL; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_SHAMT; end
            FN_SRL:  begin rtype_ctl.op = ALU_SRL; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_SHAMT; end
            FN_SRA:  begin rtype_ctl.op = ALU_SRA; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_SHAMT; end
            FN_SLLV: begin rtype_ctl.op = ALU_SLL; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_RS; end
            FN_SRLV: begin rtype_ctl.op = ALU_SRL; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_RS; end
            FN_SRAV: begin rtype_ctl.op = ALU_SRA; rtype_ctl.asrc = ASRC_RT; rtype_ctl.bsrc = BSRC_RS; end
            FN_ADDU: rtype_ctl.op = ALU_ADD;
            FN_SUBU: rtype_ctl.op = ALU_SUB;
            FN_AND:  rtype_ctl.op = ALU_AND;
            FN_OR:   rtype_ctl.op = ALU_OR;
            FN_XOR:  rtype_ctl.op = ALU_XOR;
            FN_NOR:  rtype_ctl.op = ALU_NOR;
            FN_SLT:  rtype_ctl.op = ALU_SLT;
            FN_SLTU: rtype_ctl.op = ALU_SLTU;
            default: rtype_ctl.known = 1'b0;
        endcase
    end

    // Opcode-level selection; unsupported encodings fall back to ADD of rs and rt
    always_comb begin
        ctl = '{op: ALU_ADD, ext: EXT_SIGN, asrc: ASRC_RS, bsrc: BSRC_RT, known: 1'b0};
        unique case (opcode)
            OPC_SPECIAL: ctl = rtype_ctl;
            OPC_ADDIU, OPC_LDB, OPC_LDH, OPC_LDW, OPC_LDBU, OPC_LDHU,
            OPC_STB, OPC_STH, OPC_STW: begin
                ctl.op = ALU_ADD;  ctl.ext = EXT_SIGN; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_SLTI: begin
                ctl.op = ALU_SLT;  ctl.ext = EXT_SIGN; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_SLTIU: begin
                ctl.op = ALU_SLTU; ctl.ext = EXT_SIGN; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_ANDI: begin
                ctl.op = ALU_AND;  ctl.ext = EXT_ZERO; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_ORI: begin
                ctl.op = ALU_OR;   ctl.ext = EXT_ZERO; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_XORI: begin
                ctl.op = ALU_XOR;  ctl.ext = EXT_ZERO; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            OPC_LUI: begin
                ctl.op = ALU_PASSB; ctl.ext = EXT_UPPER; ctl.bsrc = BSRC_IMM; ctl.known = 1'b1;
            end
            default: ctl.known = 1'b0;
        endcase
    end

    always_comb begin
        // R3
        if (opcode == OPC_LDW || opcode == OPC_STW) begin
            mem_addr_ext_chk: assert (ctl.ext == EXT_SIGN && ctl.op == ALU_ADD && ctl.bsrc == BSRC_IMM);
        end
        // R13
        if (!ctl.known) begin
            unknown_add_chk: assert (ctl.op == ALU_ADD && ctl.bsrc == BSRC_RT && ctl.asrc == ASRC_RS);
        end
    end

endmodule

// File: rtl/mips_operand_sel.sv
module mips_operand_sel
    import mips_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  imm_ext_e          ext,
    input  a_src_e            asrc,
    input  b_src_e            bsrc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [4:0]        shamt,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);

    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;

    always_comb begin
        unique case (ext)
            EXT_ZERO:  imm_wide = {{PAD_W{1'b0}}, imm};
            EXT_UPPER: imm_wide = {imm, {PAD_W{1'b0}}};
            default:   imm_wide = {{PAD_W{imm[IMM_W-1]}}, imm};
        endcase
    end

    always_comb begin
        opa = (asrc == ASRC_RT) ? rt_val : rs_val;
        unique case (bsrc)
            BSRC_IMM:   opb = imm_wide;
            BSRC_SHAMT: opb = {{(DATA_W-5){1'b0}}, shamt};
            BSRC_RS:    opb = rs_val;
            default:    opb = rt_val;
        endcase
    end

    always_comb begin
        // R6
        if (ext == EXT_UPPER && bsrc == BSRC_IMM) begin
            upper_low_zero_chk: assert (opb[PAD_W-1:0] == '0 && opb[DATA_W-1 -: IMM_W] == imm);
        end
        // R4
        if (ext == EXT_ZERO && bsrc == BSRC_IMM) begin
            zero_ext_chk: assert (opb[DATA_W-1:IMM_W] == '0);
        end
    end

endmodule

// File: rtl/mips_alu_core.sv
module mips_alu_core
    import mips_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result
);

    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] sh_amt;

    assign sh_amt = opb[SH_W-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD:   result = opa + opb;
            ALU_SUB:   result = opa - opb;
            ALU_AND:   result = opa & opb;
            ALU_OR:    result = opa | opb;
            ALU_XOR:   result = opa ^ opb;
            ALU_NOR:   result = ~opa & ~opb;
            ALU_SLT:   result = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            ALU_SLTU:  result = {{(DATA_W-1){1'b0}}, (opa < opb)};
            ALU_SLL:   result = opa << sh_amt;
            ALU_SRL:   result = opa >> sh_amt;
            ALU_SRA:   result = DATA_W'($signed(opa) >>> sh_amt);
            ALU_PASSB: result = opb;
            default:   result = opa + opb;
        endcase
    end

    always_comb begin
        // R9
        if (op == ALU_SRA) begin
            sra_sign_chk: assert (result[DATA_W-1] == opa[DATA_W-1]);
        end
        // R9
        if (op == ALU_SRL && sh_amt != '0) begin
            srl_zero_fill_chk: assert (result[DATA_W-1] == 1'b0);
        end
        // R11
        if (op == ALU_SLT || op == ALU_SLTU) begin
            cmp_bool_chk: assert (result <= DATA_W'(1));
        end
        // R10
        if (op == ALU_NOR) begin
            nor_disjoint_chk: assert ((result & (opa | opb)) == '0);
        end
        // R12
        if (op == ALU_ADD) begin
            add_wrap_chk: assert (DATA_W'(result - opb) == opa);
        end
    end

endmodule

// File: rtl/mips_exec_unit.sv
module mips_exec_unit
    import mips_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_result
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } out_state_t;

    dec_ctl_t          ctl;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;
    out_state_t        st_d;
    out_state_t        st_q;

    mips_op_decoder u_dec (
        .opcode (instr_word[31:26]),
        .funct  (instr_word[5:0]),
        .ctl    (ctl)
    );

    mips_operand_sel #(.DATA_W(DATA_W)) u_opsel (
        .ext    (ctl.ext),
        .asrc   (ctl.asrc),
        .bsrc   (ctl.bsrc),
        .imm    (instr_word[15:0]),
        .shamt  (instr_word[10:6]),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .opa    (opa),
        .opb    (opb)
    );

    mips_alu_core #(.DATA_W(DATA_W)) u_alu (
        .op     (ctl.op),
        .opa    (opa),
        .opb    (opb),
        .result (alu_res)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid && ctl.known;
        if (in_valid) begin
            st_d.result = alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));

    // R2
    valid_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R14
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(out_result) && !out_valid));

    // R13
    unknown_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr_word[31:26] == 6'h02) |=> !out_valid);

endmodule

// File: tb/mips_exec_unit_bench.sv
module mips_exec_unit_bench;

    typedef struct packed {
        logic        v;
        logic [31:0] r;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        out_valid;
    logic [31:0] out_result;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] last_res = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mips_exec_unit u_mips_exec_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .instr_word (instr_word),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input logic [15:0] imm);
        return {opc, 5'd3, 5'd4, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] sa);
        return {6'h00, 5'd3, 5'd4, 5'd5, sa, fn};
    endfunction

    // Expected result and validity from the requirement text
    function automatic exp_t model(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b);
        exp_t        e;
        logic [15:0] im;
        logic [31:0] se;
        logic [31:0] ze;
        im    = iw[15:0];
        se    = {{16{im[15]}}, im};
        ze    = {16'h0, im};
        e.v   = 1'b1;
        e.r   = a + b;
        e.req = 8'd0;
        case (iw[31:26])
            6'h09, 6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2B: e.r = a + se;
            6'h0A: e.r = {31'h0, ($signed(a) < $signed(se))};
            6'h0B: e.r = {31'h0, (a < se)};
            6'h0C: e.r = a & ze;
            6'h0D: e.r = a | ze;
            6'h0E: e.r = a ^ ze;
            6'h0F: e.r = {im, 16'h0};
            6'h00: begin
                case (iw[5:0])
                    6'h00: e.r = b << iw[10:6];
                    6'h02: e.r = b >> iw[10:6];
                    6'h03: e.r = $signed(b) >>> iw[10:6];
                    6'h04: e.r = b << a[4:0];
                    6'h06: e.r = b >> a[4:0];
                    6'h07: e.r = $signed(b) >>> a[4:0];
                    6'h21: e.r = a + b;
                    6'h23: e.r = a - b;
                    6'h24: e.r = a & b;
                    6'h25: e.r = a | b;
                    6'h26: e.r = a ^ b;
                    6'h27: e.r = ~(a | b);
                    6'h2A: e.r = {31'h0, ($signed(a) < $signed(b))};
                    6'h2B: e.r = {31'h0, (a < b)};
                    default: e.v = 1'b0;
                endcase
            end
            default: e.v = 1'b0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] req);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        instr_word = iw;
        rs_val     = a;
        rt_val     = b;
        e          = model(iw, a, b);
        e.req      = req;
        last_res   = e.r;
        sb_q.push_back(e);
    endtask

    task automatic idle(input logic [7:0] req);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b0;
        instr_word = enc_r(6'h21, 5'd0);
        rs_val     = 32'hDEAD_BEEF;
        rt_val     = 32'h1234_5678;
        e.v        = 1'b0;
        e.r        = last_res;
        e.req      = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares one scoreboard entry per cycle, one time unit after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (out_valid !== e.v || out_result !== e.r) begin
                    n_fails++;
                    $display("FAIL R%0d: valid=%0b result=%08h, expected valid=%0b result=%08h",
                             e.req, out_valid, out_result, e.v, e.r);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL R2: watchdog expired, actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 32'h0) begin
            n_fails++;
            $display("FAIL R1: valid=%0b result=%08h, expected valid=0 result=00000000",
                     out_valid, out_result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(8'd1);                                                    // R1 first cycle out of reset

        drive(enc_i(6'h09, 16'hFFFC), 32'h0000_0010, 32'h0, 8'd3);     // R3 ADDIU negative
        drive(enc_i(6'h23, 16'h0008), 32'h1000_0000, 32'h0, 8'd3);     // R3 load word address
        drive(enc_i(6'h28, 16'h8000), 32'h1000_8000, 32'h0, 8'd3);     // R3 store byte, negative offset
        drive(enc_i(6'h24, 16'hFFFF), 32'h0000_0000, 32'h0, 8'd3);     // R3 wrap to all ones
        drive(enc_i(6'h0C, 16'h8001), 32'hFFFF_FFFF, 32'h0, 8'd4);     // R4 ANDI
        drive(enc_i(6'h0D, 16'hF000), 32'h0000_000F, 32'h0, 8'd4);     // R4 ORI
        drive(enc_i(6'h0E, 16'hFFFF), 32'hAAAA_AAAA, 32'h0, 8'd4);     // R4 XORI
        drive(enc_i(6'h0A, 16'hFFFF), 32'h0000_0005, 32'h0, 8'd5);     // R5 SLTI: 5 < -1 false
        drive(enc_i(6'h0B, 16'hFFFF), 32'h0000_0005, 32'h0, 8'd5);     // R5 SLTIU: 5 < 0xFFFFFFFF true
        drive(enc_i(6'h0A, 16'h0001), 32'hFFFF_FFF0, 32'h0, 8'd5);     // R5 SLTI negative rs
        drive(enc_i(6'h0F, 16'hBEEF), 32'h1234_5678, 32'h0, 8'd6);     // R6 LUI ignores rs
        drive(enc_r(6'h00, 5'd4),  32'h0, 32'h0000_00F1, 8'd7);        // R7 SLL
        drive(enc_r(6'h02, 5'd4),  32'h0, 32'h8000_0000, 8'd7);        // R7 SRL, R9 zero fill
        drive(enc_r(6'h03, 5'd31), 32'h0, 32'h8000_0000, 8'd7);        // R7 SRA full width
        drive(enc_r(6'h04, 5'd0),  32'hFFFF_FFE1, 32'h0000_0003, 8'd8); // R8 SLLV uses rs[4:0]=1
        drive(enc_r(6'h06, 5'd7),  32'h0000_0028, 32'hF000_0000, 8'd8); // R8 SRLV ignores shamt
        drive(enc_r(6'h07, 5'd0),  32'h0000_0023, 32'h8000_0010, 8'd9); // R9 SRAV sign fill
        drive(enc_r(6'h07, 5'd0),  32'h0000_0004, 32'h7000_0000, 8'd9); // R9 SRAV positive
        drive(enc_r(6'h27, 5'd0),  32'hF0F0_0000, 32'h0000_0F0F, 8'd10); // R10 NOR
        drive(enc_r(6'h24, 5'd0),  32'hFF00_FF00, 32'h0FF0_0FF0, 8'd10); // R10 AND
        drive(enc_r(6'h26, 5'd0),  32'hFF00_FF00, 32'h0FF0_0FF0, 8'd10); // R10 XOR
        drive(enc_r(6'h2A, 5'd0),  32'h8000_0000, 32'h0000_0001, 8'd11); // R11 SLT signed true
        drive(enc_r(6'h2B, 5'd0),  32'h8000_0000, 32'h0000_0001, 8'd11); // R11 SLTU unsigned false
        drive(enc_r(6'h2A, 5'd0),  32'h0000_0007, 32'h0000_0007, 8'd11); // R11 equal gives 0
        drive(enc_r(6'h21, 5'd0),  32'hFFFF_FFFF, 32'h0000_0002, 8'd12); // R12 ADDU wrap
        drive(enc_r(6'h23, 5'd0),  32'h0000_0000, 32'h0000_0001, 8'd12); // R12 SUBU wrap
        drive(enc_i(6'h02, 16'h1234), 32'h0000_0100, 32'h0000_0023, 8'd13); // R13 jump opcode
        drive(enc_r(6'h18, 5'd0),  32'h0000_0005, 32'h0000_0006, 8'd13); // R13 multiply funct
        drive(enc_r(6'h21, 5'd0),  32'h0000_1111, 32'h0000_2222, 8'd2);  // R2 back to valid
        idle(8'd14);                                                     // R14 hold
        idle(8'd14);                                                     // R14 hold again
        drive(enc_i(6'h2B, 16'h0004), 32'h1000_0FFC, 32'h0, 8'd3);      // R3 store word
        idle(8'd14);

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule